// File: doc/BRIEF.md
# Mailbox Memory Loader with Running CRC-16

This block lets a host fill an on-chip memory one 32-bit word at a time through a narrow 16-bit register port, such as the one a management bus serializer would present. The host first sets a 32-bit start address by writing its two halves into two address registers. For each word it then writes the two data halves and issues a commit command. The block drives a single-cycle write strobe on a plain synchronous memory port, and then advances its address by four bytes. Consecutive words therefore land in consecutive locations without the address being rewritten.

Every committed word is also folded into a running CRC-16. The generator is 0x1021, with no reflection and no final XOR. The word's bytes are fed most significant first, and the fold for a whole word completes in one clock. When the host has fewer than four bytes left for its last word, it pads the unused bytes with zeros and commits the full word. The host reads the CRC register at any time to check the load against its own calculation. A command bit clears the CRC to zero at the start of a transfer.

Register index map (3-bit index): 1 = command (write) / status (read), 2 = CRC (read-only), 3 = address upper half, 4 = address lower half, 5 = data upper half, 6 = data lower half. All other indices read as zero and writes to them do nothing.

Top module: `mbx_loader`

## Requirements
- R1: After reset, the CRC register (index 2) reads 0x0000, the address registers read 0, the status read of index 1 is 0, and `mem_we` is low.
- R2: A write to index 3 sets address bits 31:16 and a write to index 4 sets address bits 15:0. Indices 3 and 4 read back the current address halves.
- R3: A write to index 5 sets data bits 31:16 and a write to index 6 sets data bits 15:0. Indices 5 and 6 read back the held data halves.
- R4: Writing index 1 with bit 15 (execute) and bit 14 (write) both set drives `mem_we` high in the following cycle, for that one cycle only. In that cycle `mem_addr` carries the current address and `mem_wdata` carries the assembled data word.
- R5: A command write that has only one of bits 15 and 14 set, or neither, produces no memory write and leaves the CRC and the address unchanged.
- R6: Each commit updates the CRC to CRC16(poly 0x1021, no reflection, no final XOR) over the word's four bytes, most significant byte first, starting from the previous CRC value. The new value is readable at index 2 in the cycle after the command write. A zero-padded final word is folded as a full four-byte word.
- R7: Command bit 12 clears the CRC to zero. If bit 12 arrives together with a commit, the clear is applied first and the committed word is then folded into zero.
- R8: After each commit the current address increases by 4. Back-to-back commits write consecutive word addresses.
- R9: Command bits do not persist. Reading index 1 returns the busy flag in bit 0, with all other bits zero. Busy is 1 in the cycle `mem_we` is high and 0 once the write has completed.
- R10: Writes to index 2 are ignored, and the CRC keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| mem_we | output | 1 | Memory write strobe, one cycle per committed word |
| mem_addr | output | 32 | Memory byte address of the word being written |
| mem_wdata | output | 32 | Memory write data |

## Verification
Two of the block's functions can act in the same cycle: clearing the CRC and folding a committed word. The bench sweeps all eight combinations of the clear, execute and write bits on the same command write, and it does so from a non-zero CRC. Each case is judged against a bytewise CRC model of the bench's own: a clear together with a commit must produce the fold of that word from zero, and a clear alone must produce zero. A second contention is a commit in the cycle right after another commit. Back-to-back commits are judged by the address stepping and the CRC chaining across adjacent write pulses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned WORD_W = 2 * REG_W;
  localparam int unsigned IDX_W  = 3;

  localparam logic [IDX_W-1:0] IDX_CMD   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CRC   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_ADDRH = 3'd3;
  localparam logic [IDX_W-1:0] IDX_ADDRL = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DATAH = 3'd5;
  localparam logic [IDX_W-1:0] IDX_DATAL = 3'd6;

  localparam int unsigned BIT_EXEC  = 15;
  localparam int unsigned BIT_WRITE = 14;
  localparam int unsigned BIT_CLR   = 12;

  // Fold a whole word, most significant bit first (same as bytes MSB first).
  function automatic logic [15:0] crc_fold_word(input logic [15:0] crc_in,
                                                input logic [WORD_W-1:0] word,
                                                input logic [15:0] poly);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[15] ^ word[i];
      c  = {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
    end
    return c;
  endfunction
endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0] data_word,
  output logic              commit_ev,
  output logic              crc_clr_ev,
  output logic              addr_hi_ld,
  output logic              addr_lo_ld
);
  logic [REG_W-1:0] data_hi_q, data_lo_q;
  logic             cmd_wr;

  assign cmd_wr     = reg_we && (reg_addr == IDX_CMD);
  assign commit_ev  = cmd_wr && reg_wdata[BIT_EXEC] && reg_wdata[BIT_WRITE];
  assign crc_clr_ev = cmd_wr && reg_wdata[BIT_CLR];
  assign addr_hi_ld = reg_we && (reg_addr == IDX_ADDRH);
  assign addr_lo_ld = reg_we && (reg_addr == IDX_ADDRL);
  assign data_word  = {data_hi_q, data_lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_hi_q <= '0;
      data_lo_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == IDX_DATAH) data_hi_q <= reg_wdata;
      if (reg_addr == IDX_DATAL) data_lo_q <= reg_wdata;
    end
  end
endmodule

// File: rtl/mbx_addr_port.sv
module mbx_addr_port
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_hi_ld,
  input  logic              addr_lo_ld,
  input  logic [REG_W-1:0]  ld_val,
  input  logic              commit_ev,
  input  logic [WORD_W-1:0] data_word,
  output logic [WORD_W-1:0] cur_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(ADDR_STEP);

  logic [WORD_W-1:0] addr_q;
  assign cur_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= commit_ev;
      if (commit_ev) begin
        mem_addr  <= addr_q;
        mem_wdata <= data_word;
        addr_q    <= addr_q + STEP;
      end else if (addr_hi_ld) begin
        addr_q[WORD_W-1:REG_W] <= ld_val;
      end else if (addr_lo_ld) begin
        addr_q[REG_W-1:0] <= ld_val;
      end
    end
  end
endmodule

// File: rtl/mbx_crc.sv
module mbx_crc
  import mbx_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_clr_ev,
  input  logic              commit_ev,
  input  logic [WORD_W-1:0] data_word,
  output logic [15:0]       crc_q
);
  logic [15:0] base, nxt;

  always_comb begin
    base = crc_clr_ev ? 16'h0000 : crc_q;
    nxt  = commit_ev ? crc_fold_word(base, data_word, POLY) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= nxt;
  end
endmodule

// File: rtl/mbx_loader.sv
module mbx_loader
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_STEP = 4,
  parameter logic [15:0] CRC_POLY  = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  logic [WORD_W-1:0] data_word, cur_addr;
  logic              commit_ev, crc_clr_ev, addr_hi_ld, addr_lo_ld;
  logic [15:0]       crc_q;

  mbx_regs u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .data_word, .commit_ev, .crc_clr_ev, .addr_hi_ld, .addr_lo_ld
  );

  mbx_addr_port #(.ADDR_STEP(ADDR_STEP)) u_port (
    .clk, .rst_n, .addr_hi_ld, .addr_lo_ld, .ld_val(reg_wdata),
    .commit_ev, .data_word, .cur_addr, .mem_we, .mem_addr, .mem_wdata
  );

  mbx_crc #(.POLY(CRC_POLY)) u_crc (
    .clk, .rst_n, .crc_clr_ev, .commit_ev, .data_word, .crc_q
  );

  always_comb begin
    case (reg_addr)
      IDX_CMD:   reg_rdata = {{(REG_W-1){1'b0}}, mem_we};
      IDX_CRC:   reg_rdata = crc_q;
      IDX_ADDRH: reg_rdata = cur_addr[WORD_W-1:REG_W];
      IDX_ADDRL: reg_rdata = cur_addr[REG_W-1:0];
      IDX_DATAH: reg_rdata = data_word[WORD_W-1:REG_W];
      IDX_DATAL: reg_rdata = data_word[REG_W-1:0];
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_loader_chk.sv
module mbx_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [15:0] crc_q,
  input logic        commit_ev,
  input logic        crc_clr_ev
);
  logic host_commit;
  assign host_commit = reg_we && (reg_addr == 3'd1) && reg_wdata[15] && reg_wdata[14];

  a_r4_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_commit |=> mem_we);
  a_r5_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !host_commit |=> !mem_we);
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && host_commit) |=> (mem_addr == $past(mem_addr) + 32'd4));
  a_r10_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_ev && !crc_clr_ev) |=> $stable(crc_q));
  a_r7_crc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_clr_ev && !commit_ev) |=> (crc_q == 16'h0000));
endmodule

bind mbx_loader mbx_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
  .crc_q(crc_q), .commit_ev(commit_ev), .crc_clr_ev(crc_clr_ev)
);

// File: tb/tb_mbx_loader.sv
module tb_mbx_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;

  int total = 0, bad = 0;

  mbx_loader dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog: expected finish, got timeout");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [15:0] m_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  function automatic logic [15:0] m_word(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] x;
    x = c;
    x = m_byte(x, w[31:24]);
    x = m_byte(x, w[23:16]);
    x = m_byte(x, w[15:8]);
    x = m_byte(x, w[7:0]);
    return x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write takes effect at the next posedge; outputs sampled 1 time unit later.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  logic [15:0] v, crc_m;
  logic [31:0] addr_m, lcg;

  initial begin
    #(CLK_PERIOD*2 + 1);
    rst_n = 1;
    idle();
    // R1 reset state
    rd(3'd2, v); chk("R1 crc", v, 0);
    rd(3'd3, v); chk("R1 addr hi", v, 0);
    rd(3'd4, v); chk("R1 addr lo", v, 0);
    rd(3'd1, v); chk("R1 status", v, 0);
    chk("R1 mem_we", mem_we, 0);

    // R2, R3 loads and readback
    wr(3'd3, 16'h0001); wr(3'd4, 16'h0F00);
    rd(3'd3, v); chk("R2 addr hi", v, 16'h0001);
    rd(3'd4, v); chk("R2 addr lo", v, 16'h0F00);
    wr(3'd5, 16'h3132); wr(3'd6, 16'h3334);
    rd(3'd5, v); chk("R3 data hi", v, 16'h3132);
    rd(3'd6, v); chk("R3 data lo", v, 16'h3334);
    addr_m = 32'h0001_0F00; crc_m = 0;

    // R4/R6/R8/R9 single commit
    wr(3'd1, 16'hC000);
    crc_m = m_word(crc_m, 32'h31323334);
    chk("R4 mem_we", mem_we, 1);
    chk("R4 mem_addr", mem_addr, addr_m);
    chk("R4 mem_wdata", mem_wdata, 32'h31323334);
    rd(3'd1, v); chk("R9 busy high", v, 16'h0001);
    rd(3'd2, v); chk("R6 crc", v, crc_m);
    addr_m += 4;
    idle();
    chk("R4 one cycle", mem_we, 0);
    rd(3'd1, v); chk("R9 busy low", v, 16'h0000);
    rd(3'd4, v); chk("R8 addr step", v, addr_m[15:0]);

    // R10 write to CRC index ignored
    wr(3'd2, 16'hBEEF);
    rd(3'd2, v); chk("R10 crc kept", v, crc_m);

    // R5/R7 all command bit combinations, from a non-zero CRC
    for (int c = 0; c < 8; c++) begin
      logic [15:0] cmd;
      logic        ex, wb, cl;
      ex = c[2]; wb = c[1]; cl = c[0];
      cmd = 16'h0000; cmd[15] = ex; cmd[14] = wb; cmd[12] = cl;
      wr(3'd5, 16'h0A00 + 16'(c)); wr(3'd6, 16'h55AA);
      wr(3'd1, cmd);
      if (cl) crc_m = 0;
      if (ex && wb) begin
        crc_m = m_word(crc_m, {16'h0A00 + 16'(c), 16'h55AA});
        chk("R4 combo mem_we", mem_we, 1);
        chk("R8 combo addr", mem_addr, addr_m);
        addr_m += 4;
      end else begin
        chk("R5 no write", mem_we, 0);
      end
      rd(3'd2, v); chk(cl ? "R7 clear combo crc" : "R5 crc combo", v, crc_m);
      rd(3'd4, v); chk("R5 addr combo", v, addr_m[15:0]);
      idle();
      // reseed a non-zero CRC for the next case
      wr(3'd1, 16'hC000);
      crc_m = m_word(crc_m, {16'h0A00 + 16'(c), 16'h55AA});
      addr_m += 4;
      idle();
    end

    // Back-to-back sweep with address wrap near the low half boundary
    wr(3'd3, 16'h0000); wr(3'd4, 16'hFFF0);
    addr_m = 32'h0000_FFF0;
    wr(3'd1, 16'h1000); crc_m = 0;
    lcg = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (n == 39) lcg[23:0] = 24'h0; // zero-padded final word
      wr(3'd5, lcg[31:16]); wr(3'd6, lcg[15:0]);
      wr(3'd1, 16'hC000);
      crc_m = m_word(crc_m, lcg);
      chk("R8 sweep addr", mem_addr, addr_m);
      chk("R4 sweep data", mem_wdata, lcg);
      addr_m += 4;
      // immediate second commit of the same word, back-to-back
      wr(3'd1, 16'hC000);
      crc_m = m_word(crc_m, lcg);
      chk("R8 b2b addr", mem_addr, addr_m);
      chk("R4 b2b we", mem_we, 1);
      addr_m += 4;
      rd(3'd2, v); chk("R6 sweep crc", v, crc_m);
    end
    rd(3'd3, v); chk("R8 final addr hi", v, addr_m[31:16]);
    rd(3'd4, v); chk("R8 final addr lo", v, addr_m[15:0]);

    // R6 known vector: "1234","5678" bytes from zero
    wr(3'd1, 16'h1000);
    wr(3'd5, 16'h3132); wr(3'd6, 16'h3334); wr(3'd1, 16'hC000);
    wr(3'd5, 16'h3536); wr(3'd6, 16'h3738); wr(3'd1, 16'hC000);
    rd(3'd2, v);
    chk("R6 vector", v, m_word(m_word(16'h0, 32'h31323334), 32'h35363738));
    chk("R6 vector nonzero", (v != 0), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule